// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block carries a stream of data words from one clock domain to another. A producer pushes words on its own clock with a write strobe. A consumer pops them on an unrelated clock with a read strobe. Each side sees status flags that are registered in its own domain. The write side has a full flag, an almost-full flag and a per-cycle error pulse for a write that was turned away. The read side has an empty flag, an almost-empty flag and a per-cycle error pulse for a read attempted while nothing is available.

The two domains exchange only Gray-coded pointers, and each pointer passes through a two-stage synchronizer. Every flag is registered from the synchronized copy, so the latency across the boundary is fixed. A word written on the write clock becomes visible to the read-side flags on the third rising read-clock edge after that write. One further read-clock period may be added when the two clock edges land almost together.

A build-time parameter selects the output behaviour. In fall-through mode, the oldest unread word is already waiting on the read data output whenever empty is low, and a read strobe retires it. In standard mode, the read strobe fetches the next word onto the output on the following edge. The output holds its value whenever no word is fetched.

A single asynchronous active-low reset is released synchronously in each domain.

Top module: `dual_clock_fifo`

## Requirements
- R1: While reset is asserted, and after it until the first write, full, almost_full, wr_err and rd_err are low, empty and almost_empty are high, and rd_data is zero.
- R2: Words leave the block in the order they were accepted. Empty falls on the third read-clock edge after the write clock accepts a word into an empty block. Empty rises when the last word visible to the read side has been taken.
- R3: In fall-through mode (MODE = RD_FWFT), whenever empty is low, rd_data already shows the oldest unread word without any read strobe. A read strobe with empty low retires that word, and rd_data shows the next word after the same edge if one is visible.
- R4: In standard mode (MODE = RD_STANDARD), rd_data changes only on the edge that accepts a read (rd_en high, empty low). That edge loads the oldest unread word. rd_data holds its value on every other edge.
- R5: almost_empty is high while the number of words written and not yet read, as seen by the read side, is AE_LVL or fewer. It falls on the third read-clock edge after the write that lifts that count above AE_LVL, with the same timing in both modes.
- R6: full is high when the write side counts 2^AW words outstanding that have not left the storage array. almost_full is high when that count is 2^AW − AF_LVL or more. Space freed by the read side reaches these flags on the third write-clock edge after it is freed. In fall-through mode, a word moved to the output stage frees its slot.
- R7: A write strobe while full stores nothing and moves no pointer. wr_err is high for exactly the write-clock cycle after each such rejected strobe.
- R8: A read strobe while empty changes no state. rd_err is high for exactly the read-clock cycle after each such ignored strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word to store |
| full | output | 1 | No free slot (write domain) |
| almost_full | output | 1 | AF_LVL or fewer free slots (write domain) |
| wr_err | output | 1 | Previous write strobe was rejected |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Output word |
| empty | output | 1 | No unread word available (read domain) |
| almost_empty | output | 1 | AE_LVL or fewer unread words (read domain) |
| rd_err | output | 1 | Previous read strobe was ignored |

## Verification
Suppose a pointer is corrupted or the synchronizer depth is wrong. The flag edges then move away from the third edge in the other domain, and a clock-by-clock reference model sees the move at once. Suppose a slot is overwritten, a word is skipped or the prefetch stage loads at the wrong moment. rd_data then differs from the model on the first read of the affected word. A rejected write that still advances the pointer does not show when the error pulse appears. It shows as a duplicated or shifted word about two to four read cycles later, when the read side reaches that slot.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  // Output behaviour of the read port
  typedef enum logic {
    RD_STANDARD = 1'b0,
    RD_FWFT     = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/afifo_rst_sync.sv
module afifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/afifo_ptr_sync.sv
module afifo_ptr_sync #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  // Gray to binary: each bit is the parity of itself and all bits above it
  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[PW-1:i];
  end
endmodule

// File: rtl/afifo_wr_side.sv
module afifo_wr_side #(
  parameter int AW     = 4,
  parameter int AF_LVL = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rd_bin_s,
  output logic [AW:0]   bin_o,
  output logic [AW:0]   gray_o,
  output logic          we_o,
  output logic          full_o,
  output logic          afull_o,
  output logic          err_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d, rd_gray, used_d;
  logic          full_q, full_d, af_q, af_d, err_q, err_d, accept;

  assign accept  = wr_en & ~full_q;
  assign rd_gray = rd_bin_s ^ (rd_bin_s >> 1);

  always_comb begin
    bin_d  = bin_q + PW'(accept);
    gray_d = bin_d ^ (bin_d >> 1);
    used_d = bin_d - rd_bin_s;
    // full: Gray pointers differ only in their two top bits
    full_d = (gray_d == {~rd_gray[PW-1:PW-2], rd_gray[PW-3:0]});
    af_d   = (used_d >= PW'(DEPTH - AF_LVL));
    err_d  = wr_en & full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      full_q <= 1'b0;
      af_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      full_q <= full_d;
      af_q   <= af_d;
      err_q  <= err_d;
    end
  end

  assign bin_o   = bin_q;
  assign gray_o  = gray_q;
  assign we_o    = accept;
  assign full_o  = full_q;
  assign afull_o = af_q;
  assign err_o   = err_q;
endmodule

// File: rtl/afifo_rd_side.sv
module afifo_rd_side
  import afifo_pkg::*;
#(
  parameter int       DW     = 8,
  parameter int       AW     = 4,
  parameter int       AE_LVL = 3,
  parameter rd_mode_e MODE   = RD_FWFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wr_bin_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   gray_o,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o,
  output logic          aempty_o,
  output logic          err_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d, cons_d, cnt_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          empty_q, empty_d, ae_q, ae_d, err_q, err_d;
  logic          take, load, hold;

  // A word is handed to the user when a strobe meets a non-empty port
  assign take = rd_en & ~empty_q;

  if (MODE == RD_FWFT) begin : g_fwft
    // Refill the output stage when it is vacant or being retired
    assign load = (empty_q | take) & (wr_bin_s != bin_q);
    assign hold = load | (~empty_q & ~take);
  end else begin : g_std
    assign load = take;
    assign hold = 1'b0;
  end

  always_comb begin
    bin_d   = bin_q + PW'(load);
    gray_d  = bin_d ^ (bin_d >> 1);
    cons_d  = bin_d - PW'(hold);      // words retired by the user
    cnt_d   = wr_bin_s - cons_d;      // unread words seen by this side
    empty_d = (cnt_d == '0);
    ae_d    = (cnt_d <= PW'(AE_LVL));
    err_d   = rd_en & empty_q;
    dout_d  = load ? mem_rdata : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q   <= '0;
      gray_q  <= '0;
      dout_q  <= '0;
      empty_q <= 1'b1;
      ae_q    <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      bin_q   <= bin_d;
      gray_q  <= gray_d;
      dout_q  <= dout_d;
      empty_q <= empty_d;
      ae_q    <= ae_d;
      err_q   <= err_d;
    end
  end

  assign raddr_o   = bin_q[AW-1:0];
  assign gray_o    = gray_q;
  assign rd_data_o = dout_q;
  assign empty_o   = empty_q;
  assign aempty_o  = ae_q;
  assign err_o     = err_q;
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import afifo_pkg::*;
#(
  parameter int       DW     = 8,
  parameter int       AW     = 4,
  parameter int       AE_LVL = 3,
  parameter int       AF_LVL = 3,
  parameter rd_mode_e MODE   = RD_FWFT
) (
  input  logic          arst_n,
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  output logic          wr_err,
  input  logic          rd_clk,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty,
  output logic          rd_err
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          wr_rst_n, rd_rst_n, mem_we;
  logic [PW-1:0] w_bin, w_gray, r_gray, w_bin_rs, r_bin_ws;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] store [DEPTH];

  afifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(arst_n), .rst_n(wr_rst_n));
  afifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(arst_n), .rst_n(rd_rst_n));

  afifo_wr_side #(.AW(AW), .AF_LVL(AF_LVL)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rd_bin_s(r_bin_ws),
    .bin_o(w_bin), .gray_o(w_gray), .we_o(mem_we),
    .full_o(full), .afull_o(almost_full), .err_o(wr_err)
  );

  afifo_ptr_sync #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .gray_i(r_gray), .bin_o(r_bin_ws)
  );

  afifo_ptr_sync #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .gray_i(w_gray), .bin_o(w_bin_rs)
  );

  // Storage array: written on the write clock, read through the output stage
  always_ff @(posedge wr_clk) begin
    if (mem_we) begin
      store[w_bin[AW-1:0]] <= wr_data;
    end
  end

  assign mem_rdata = store[r_addr];

  afifo_rd_side #(.DW(DW), .AW(AW), .AE_LVL(AE_LVL), .MODE(MODE)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wr_bin_s(w_bin_rs),
    .mem_rdata(mem_rdata), .raddr_o(r_addr), .gray_o(r_gray),
    .rd_data_o(rd_data), .empty_o(empty), .aempty_o(almost_empty),
    .err_o(rd_err)
  );
endmodule

// File: rtl/dual_clock_fifo_chk.sv
module dual_clock_fifo_chk #(
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter bit FWFT = 1'b1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n,
  input logic          rd_rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full,
  input logic          almost_full,
  input logic          wr_err,
  input logic          empty,
  input logic          almost_empty,
  input logic          rd_err,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   wr_ptr,
  input logic [AW:0]   rd_ptr_ws
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  AST_WERR_CAUSE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_err |-> $past(wr_en && full)); // R7
  AST_FULL_FREEZES_PTR: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && full) |=> $stable(wr_ptr)); // R7
  AST_FULL_IMPLIES_AF: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full |-> almost_full); // R6
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_ptr - rd_ptr_ws) <= PW'(DEPTH)); // R6
  AST_RERR_CAUSE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_err |-> $past(rd_en && empty)); // R8
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    empty |-> almost_empty); // R5
  AST_STD_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!FWFT && (!rd_en || empty)) |=> $stable(rd_data)); // R4
  AST_FWFT_HEAD_HELD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (FWFT && !empty && !rd_en) |=> $stable(rd_data)); // R3
endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(
  .DW(DW), .AW(AW), .FWFT(MODE == afifo_pkg::RD_FWFT)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .almost_full(almost_full),
  .wr_err(wr_err), .empty(empty), .almost_empty(almost_empty), .rd_err(rd_err),
  .rd_data(rd_data), .wr_ptr(w_bin), .rd_ptr_ws(r_bin_ws)
);

// File: tb/dual_clock_fifo_test.sv
module dual_clock_fifo_test;
  localparam int DW = 8, AW = 4, AE = 3, AF = 3;
  localparam int DEPTH = 1 << AW;

  logic arst_n, wr_clk, rd_clk, wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic [1:0] full_o, af_o, werr_o, empty_o, ae_o, rerr_o;
  logic [DW-1:0] rdata_o [2];

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0, done = 0;

  // reference model, index 0 = fall-through, 1 = standard
  int wcnt [2] = '{0, 0};
  int cons [2] = '{0, 0};
  int freed [2] = '{0, 0};
  int u1 [2] = '{0, 0};
  int u2 [2] = '{0, 0};
  int v1 [2] = '{0, 0};
  int v2 [2] = '{0, 0};
  bit full_e [2] = '{0, 0};
  bit af_e [2] = '{0, 0};
  bit werr_e [2] = '{0, 0};
  bit empty_e [2] = '{1, 1};
  bit ae_e [2] = '{1, 1};
  bit rerr_e [2] = '{0, 0};
  logic [DW-1:0] dout_e [2] = '{8'h00, 8'h00};
  logic [DW-1:0] log_m [2][256];

  dual_clock_fifo #(.DW(DW), .AW(AW), .AE_LVL(AE), .AF_LVL(AF),
                    .MODE(afifo_pkg::RD_FWFT)) uut (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .full(full_o[0]), .almost_full(af_o[0]), .wr_err(werr_o[0]),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rdata_o[0]),
    .empty(empty_o[0]), .almost_empty(ae_o[0]), .rd_err(rerr_o[0]));

  dual_clock_fifo #(.DW(DW), .AW(AW), .AE_LVL(AE), .AF_LVL(AF),
                    .MODE(afifo_pkg::RD_STANDARD)) uut_std (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .full(full_o[1]), .almost_full(af_o[1]), .wr_err(werr_o[1]),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rdata_o[1]),
    .empty(empty_o[1]), .almost_empty(ae_o[1]), .rd_err(rerr_o[1]));

  // both clocks at 100 MHz, read edges half a period after write edges
  initial begin
    wr_clk = 0;
    forever #5 wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 1;
    forever #5 rd_clk = ~rd_clk;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // write-domain model
  always @(posedge wr_clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!arst_n) begin
        wcnt[m] = 0; u1[m] = 0; u2[m] = 0;
        full_e[m] = 0; af_e[m] = 0; werr_e[m] = 0;
      end else begin
        int used;
        werr_e[m] = wr_en && full_e[m];
        if (wr_en && !full_e[m]) begin
          log_m[m][wcnt[m] % 256] = wr_data;
          wcnt[m]++;
        end
        used = wcnt[m] - u2[m];
        full_e[m] = (used == DEPTH);
        af_e[m] = (used >= DEPTH - AF);
        u2[m] = u1[m];
        u1[m] = freed[m];
      end
    end
    #2;
    if (chk_on) begin
      for (int m = 0; m < 2; m++) begin
        chk("R6", $sformatf("full m%0d", m), int'(full_o[m]), int'(full_e[m]));
        chk("R6", $sformatf("almost_full m%0d", m), int'(af_o[m]), int'(af_e[m]));
        chk("R7", $sformatf("wr_err m%0d", m), int'(werr_o[m]), int'(werr_e[m]));
      end
    end
  end

  // read-domain model
  always @(posedge rd_clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!arst_n) begin
        cons[m] = 0; freed[m] = 0; v1[m] = 0; v2[m] = 0;
        empty_e[m] = 1; ae_e[m] = 1; rerr_e[m] = 0; dout_e[m] = '0;
      end else begin
        int cnt;
        rerr_e[m] = rd_en && empty_e[m];
        if (rd_en && !empty_e[m]) begin
          if (m == 1) dout_e[m] = log_m[m][cons[m] % 256];
          cons[m]++;
        end
        cnt = v2[m] - cons[m];
        empty_e[m] = (cnt == 0);
        ae_e[m] = (cnt <= AE);
        if (m == 0 && cnt > 0) dout_e[m] = log_m[m][cons[m] % 256];
        freed[m] = cons[m] + ((m == 0 && cnt > 0) ? 1 : 0);
        v2[m] = v1[m];
        v1[m] = wcnt[m];
      end
    end
    #2;
    if (chk_on) begin
      for (int m = 0; m < 2; m++) begin
        chk("R2", $sformatf("empty m%0d", m), int'(empty_o[m]), int'(empty_e[m]));
        chk("R5", $sformatf("almost_empty m%0d", m), int'(ae_o[m]), int'(ae_e[m]));
        chk("R8", $sformatf("rd_err m%0d", m), int'(rerr_o[m]), int'(rerr_e[m]));
      end
      chk("R3", "rd_data fall-through", int'(rdata_o[0]), int'(dout_e[0]));
      chk("R4", "rd_data standard", int'(rdata_o[1]), int'(dout_e[1]));
    end
  end

  task automatic step(input logic we, input logic [DW-1:0] d, input logic re);
    @(posedge wr_clk);
    #2;
    wr_en = we; wr_data = d; rd_en = re;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    logic [15:0] lfsr;
    arst_n = 1; wr_en = 0; rd_en = 0; wr_data = '0;
    #1 arst_n = 0;
    #2 chk_on = 1;
    repeat (3) @(posedge wr_clk);
    #2;
    for (int m = 0; m < 2; m++) begin
      chk("R1", "reset full", int'(full_o[m]), 0);
      chk("R1", "reset almost_full", int'(af_o[m]), 0);
      chk("R1", "reset wr_err", int'(werr_o[m]), 0);
      chk("R1", "reset empty", int'(empty_o[m]), 1);
      chk("R1", "reset almost_empty", int'(ae_o[m]), 1);
      chk("R1", "reset rd_err", int'(rerr_o[m]), 0);
      chk("R1", "reset rd_data", int'(rdata_o[m]), 0);
    end
    #1 arst_n = 1;
    repeat (6) step(0, '0, 0);

    // R5: fourth word lifts the count past AE; flag falls on 3rd read edge
    step(1, 8'h11, 0); step(1, 8'h22, 0); step(1, 8'h33, 0); step(1, 8'h44, 0);
    step(0, '0, 0);
    for (int k = 1; k <= 3; k++) begin
      @(posedge rd_clk);
      #3;
      for (int m = 0; m < 2; m++)
        chk("R5", $sformatf("almost_empty edge %0d m%0d", k, m), int'(ae_o[m]), (k < 3) ? 1 : 0);
    end

    // R6/R7: overfill, rejected writes raise wr_err
    for (int i = 0; i < 18; i++) step(1, DW'(8'h40 + i), 0);
    repeat (8) step(0, '0, 0);
    for (int m = 0; m < 2; m++) chk("R6", $sformatf("full after fill m%0d", m), int'(full_o[m]), 1);

    // R2/R8: drain past empty
    for (int i = 0; i < 24; i++) step(0, '0, 1);
    repeat (8) step(0, '0, 0);
    for (int m = 0; m < 2; m++) chk("R2", $sformatf("empty after drain m%0d", m), int'(empty_o[m]), 1);

    // mixed traffic, alternating write-heavy and read-heavy phases
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if ((i / 250) % 2 == 0)
        step(lfsr[2:0] != 3'd0, lfsr[15:8], lfsr[5:3] == 3'd0);
      else
        step(lfsr[2:0] == 3'd0, lfsr[15:8], lfsr[5:4] != 2'd0);
    end
    for (int i = 0; i < 30; i++) step(0, '0, 1);
    repeat (6) step(0, '0, 0);
    for (int m = 0; m < 2; m++) chk("R2", $sformatf("empty at end m%0d", m), int'(empty_o[m]), 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge wr_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule